// File: doc/BRIEF.md
# Double-Buffered Serial Converter Word Register

This block is the digital front end of a 16-bit serial-input converter. A host streams data bits over a serial clock and data line, framing each transfer with an active-low select. Bits land in an input shift register, and a separate output register holds the word that drives the converter switches. The two registers are distinct, so a new word can be shifted in while the old word is still being converted. The word moves from the shift register to the output register at the end of the frame, or later under an optional active-low load strobe.

All four serial-side inputs are asynchronous to the system clock. Each passes through a multi-stage synchronizer, and the block detects edges in the system-clock domain. Each transfer into the output register is flagged by a single-cycle pulse in that domain. Reset clears the output register. It leaves the shift register alone, so whatever that register held before reset is kept. A frame may be short or long: the shift register simply keeps shifting, so the last sixteen bits win.

Top module: `dacreg_serial_latch`

## Requirements
- R1: While `rst` is high and after it falls, `out_word` is 0x0000 and `latch_updated` is 0 until the first transfer.
- R2: Bits are taken on rising edges of `ser_clk` while `frame_sel_n` is low, most significant bit first. With `load_strobe_n` low, a rising `frame_sel_n` copies the 16-bit shift register into `out_word`.
- R3: `latch_updated` is high for exactly one `clk` cycle per transfer, in the cycle in which `out_word` takes the new value. `out_word` never changes without that pulse.
- R4: When a frame carries more than 16 bits, `out_word` receives the last 16 bits clocked.
- R5: When a frame carries N < 16 bits, the low N bits of the word are the new bits. The upper 16-N bits are the previous shift content moved up by N positions.
- R6: Toggling `ser_clk` and `ser_data` while `frame_sel_n` is high changes neither register. An empty frame that follows reloads the unchanged shift content.
- R7: A rising `frame_sel_n` while `load_strobe_n` is high does not transfer. `out_word` and `latch_updated` do not change.
- R8: A falling `load_strobe_n` while `frame_sel_n` is high transfers the shift register into `out_word`.
- R9: A falling `load_strobe_n` while `frame_sel_n` is low (mid-frame) is ignored. The frame end that follows, with the strobe still low, transfers as in R2.
- R10: Reset does not clear the shift register. A word shifted in before reset can be transferred after reset by the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; clears the output register only |
| ser_clk | input | 1 | Asynchronous serial bit clock; data is taken on its rising edge |
| ser_data | input | 1 | Asynchronous serial data, MSB first |
| frame_sel_n | input | 1 | Asynchronous active-low frame select |
| load_strobe_n | input | 1 | Asynchronous active-low load strobe; tie low for transfer at frame end |
| out_word | output | 16 | Output register contents |
| latch_updated | output | 1 | One-cycle pulse on each transfer into `out_word` |

## Verification
The bench checks frames that are too long and too short. A design that cleared or resized the shift register per frame would lose the upper carried-over bits of a short frame, or would keep the first bits of a long frame instead of the last. It toggles the serial lines while deselected and then sends an empty frame: a shifter that ignored the select would reload a corrupted word. The strobe is exercised at the frame end, between frames and mid-frame, to catch a design that transfers on the wrong edge or level. It also resets between shifting and strobing, which exposes a design that wipes the shift register on reset.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;

    localparam int DEF_WORD_W      = 16;
    localparam int DEF_SYNC_STAGES = 2;

    // Synchronized serial-side levels and the edges derived from them.
    typedef struct packed {
        logic clk_rise;     // serial clock rising edge
        logic frame_end;    // frame select rising edge
        logic strobe_fall;  // load strobe falling edge
        logic sel_n;        // synchronized frame select level
        logic strobe_n;     // synchronized load strobe level
        logic data;         // synchronized serial data level
    } ser_evt_t;

    typedef enum logic [1:0] {
        LOAD_NONE   = 2'd0,
        LOAD_FRAME  = 2'd1,
        LOAD_STROBE = 2'd2
    } load_src_t;

    // Frame end with the strobe held low loads; a strobe fall only
    // loads between frames.
    function automatic load_src_t pick_load(input ser_evt_t e);
        if (e.frame_end && !e.strobe_n)
            return LOAD_FRAME;
        else if (e.strobe_fall && e.sel_n)
            return LOAD_STROBE;
        else
            return LOAD_NONE;
    endfunction

    function automatic logic shift_enabled(input ser_evt_t e);
        return e.clk_rise && !e.sel_n;
    endfunction

endpackage

// File: rtl/dacreg_sync.sv
module dacreg_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    localparam int TOP = STAGES - 1;

    // Synchronizer flops carry no reset: they settle while reset is held.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        if (STAGES > 1) begin : g_multi
            always_ff @(posedge clk) begin
                chain <= {chain[STAGES-2:0], d_async[i]};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                chain <= d_async[i];
            end
        end
        assign q_sync[i] = chain[TOP];
    end
endmodule

// File: rtl/dacreg_edges.sv
module dacreg_edges
    import dacreg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sclk_s,
    input  logic     data_s,
    input  logic     sel_n_s,
    input  logic     strobe_n_s,
    output ser_evt_t evt
);
    logic sclk_d, sel_n_d, strobe_n_d;

    // During reset the history tracks the inputs so no false edge
    // appears when reset is released.
    always_ff @(posedge clk) begin
        sclk_d     <= sclk_s;
        sel_n_d    <= sel_n_s;
        strobe_n_d <= strobe_n_s;
    end

    always_comb begin
        evt.clk_rise    = !rst && sclk_s && !sclk_d;
        evt.frame_end   = !rst && sel_n_s && !sel_n_d;
        evt.strobe_fall = !rst && !strobe_n_s && strobe_n_d;
        evt.sel_n       = sel_n_s;
        evt.strobe_n    = strobe_n_s;
        evt.data        = data_s;
    end
endmodule

// File: rtl/dacreg_shifter.sv
module dacreg_shifter
    import dacreg_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W
) (
    input  logic              clk,
    input  ser_evt_t          evt,
    output logic [WORD_W-1:0] shift_q
);
    // No reset by intent: the content survives reset and is undefined
    // at power-up.
    always_ff @(posedge clk) begin
        if (shift_enabled(evt))
            shift_q <= {shift_q[WORD_W-2:0], evt.data};
    end
endmodule

// File: rtl/dacreg_latch.sv
module dacreg_latch
    import dacreg_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  ser_evt_t          evt,
    input  logic [WORD_W-1:0] shift_q,
    output logic [WORD_W-1:0] out_word,
    output logic              latch_updated
);
    load_src_t src;

    always_comb src = pick_load(evt);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_word      <= '0;
            latch_updated <= 1'b0;
        end else begin
            latch_updated <= (src != LOAD_NONE);
            if (src != LOAD_NONE)
                out_word <= shift_q;
        end
    end
endmodule

// File: rtl/dacreg_serial_latch.sv
module dacreg_serial_latch
    import dacreg_pkg::*;
#(
    parameter int WORD_W      = DEF_WORD_W,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              frame_sel_n,
    input  logic              load_strobe_n,
    output logic [WORD_W-1:0] out_word,
    output logic              latch_updated
);
    localparam int N_IN = 4;

    logic [N_IN-1:0]   raw_in, sync_in;
    ser_evt_t          evt;
    logic [WORD_W-1:0] shift_q;

    assign raw_in = {load_strobe_n, frame_sel_n, ser_data, ser_clk};

    dacreg_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .d_async (raw_in),
        .q_sync  (sync_in)
    );

    dacreg_edges u_edges (
        .clk        (clk),
        .rst        (rst),
        .sclk_s     (sync_in[0]),
        .data_s     (sync_in[1]),
        .sel_n_s    (sync_in[2]),
        .strobe_n_s (sync_in[3]),
        .evt        (evt)
    );

    dacreg_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk     (clk),
        .evt     (evt),
        .shift_q (shift_q)
    );

    dacreg_latch #(.WORD_W(WORD_W)) u_latch (
        .clk           (clk),
        .rst           (rst),
        .evt           (evt),
        .shift_q       (shift_q),
        .out_word      (out_word),
        .latch_updated (latch_updated)
    );
endmodule

// File: rtl/dacreg_checker.sv
module dacreg_checker
    import dacreg_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W
) (
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] out_word,
    input logic              latch_updated,
    input logic [WORD_W-1:0] shift_q,
    input ser_evt_t          evt
);
    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (out_word == '0) && !latch_updated);

    // R3
    a_r3_change_needs_pulse: assert property (@(posedge clk) disable iff (rst)
        !latch_updated |-> (out_word === $past(out_word)));

    // R2
    a_r2_load_from_shift: assert property (@(posedge clk) disable iff (rst)
        latch_updated |-> (out_word === $past(shift_q)));

    // R6
    a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        (evt.sel_n || !evt.clk_rise) |=> (shift_q === $past(shift_q)));

    // R7, R9
    a_r7_no_spurious_load: assert property (@(posedge clk) disable iff (rst)
        (!evt.frame_end && !(evt.strobe_fall && evt.sel_n)) |=> !latch_updated);

    // R8
    a_r8_strobe_loads: assert property (@(posedge clk) disable iff (rst)
        (evt.strobe_fall && evt.sel_n) |=> latch_updated);
endmodule

bind dacreg_serial_latch dacreg_checker #(.WORD_W(WORD_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .out_word      (out_word),
    .latch_updated (latch_updated),
    .shift_q       (shift_q),
    .evt           (evt)
);

// File: tb/tb_dacreg_serial_latch.sv
`timescale 1ns/1ps
module tb_dacreg_serial_latch;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_data = 1'b0, frame_sel_n = 1'b1, load_strobe_n = 1'b0;
    logic [15:0] out_word;
    logic latch_updated;

    int checks = 0, fails = 0, pulses = 0, wide = 0;
    logic prev_pulse = 1'b0;
    logic [15:0] exp_sr = 16'h0;
    logic finished = 1'b0;

    always #4 clk = ~clk;

    dacreg_serial_latch dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
        .frame_sel_n(frame_sel_n), .load_strobe_n(load_strobe_n),
        .out_word(out_word), .latch_updated(latch_updated)
    );

    always @(posedge clk) begin
        if (latch_updated) pulses <= pulses + 1;
        if (latch_updated && prev_pulse) wide <= wide + 1;
        prev_pulse <= latch_updated;
    end

    task automatic waitn(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic shift_bits(input logic [31:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = bits[i];
            waitn(4);
            ser_clk = 1'b1;
            waitn(4);
            ser_clk = 1'b0;
            exp_sr = {exp_sr[14:0], bits[i]};
        end
    endtask

    task automatic send_frame(input logic [31:0] bits, input int n, input logic strobe);
        @(negedge clk);
        load_strobe_n = strobe;
        frame_sel_n = 1'b0;
        waitn(4);
        shift_bits(bits, n);
        waitn(4);
        frame_sel_n = 1'b1;
        waitn(12);
    endtask

    task automatic t_reset;
        check("R1 out_word in reset", out_word, 16'h0);
        check("R1 pulse in reset", latch_updated, 1'b0);
        rst = 1'b0;
        waitn(10);
        check("R1 out_word after reset", out_word, 16'h0);
        check("R1 no pulse after reset", pulses, 0);
    endtask

    task automatic t_auto_load(input logic [15:0] w);
        int p0 = pulses;
        send_frame({16'h0, w}, 16, 1'b0);
        check("R2 auto load word", out_word, w);
        check("R3 one pulse per transfer", pulses - p0, 1);
    endtask

    task automatic t_overlong;
        send_frame(32'h000F_1234, 20, 1'b0);
        check("R4 last sixteen kept", out_word, 16'h1234);
    endtask

    task automatic t_short;
        send_frame(32'h0000_00CD, 8, 1'b0);
        check("R5 short frame merge", out_word, 16'h34CD);
        check("R5 bench model", out_word, exp_sr);
    endtask

    task automatic t_idle_noise;
        int p0 = pulses;
        logic [15:0] keep = out_word;
        @(negedge clk);
        load_strobe_n = 1'b0;
        for (int i = 0; i < 10; i++) begin
            ser_data = i[0];
            waitn(3);
            ser_clk = 1'b1;
            waitn(3);
            ser_clk = 1'b0;
        end
        waitn(8);
        check("R6 no load from idle toggling", pulses - p0, 0);
        send_frame(32'h0, 0, 1'b0);
        check("R6 shift content unchanged", out_word, keep);
    endtask

    task automatic t_strobe;
        int p0 = pulses;
        logic [15:0] keep = out_word;
        send_frame(32'h0000_BEEF, 16, 1'b1);
        check("R7 held strobe blocks load", out_word, keep);
        check("R7 no pulse", pulses - p0, 0);
        load_strobe_n = 1'b0;
        waitn(10);
        check("R8 strobe loads word", out_word, 16'hBEEF);
        check("R8 one pulse", pulses - p0, 1);
    endtask

    task automatic t_strobe_midframe;
        int p0 = pulses;
        @(negedge clk);
        load_strobe_n = 1'b1;
        frame_sel_n = 1'b0;
        waitn(4);
        shift_bits(32'h0F, 8);
        load_strobe_n = 1'b0;
        waitn(10);
        check("R9 mid-frame strobe ignored", out_word, 16'hBEEF);
        check("R9 no pulse mid-frame", pulses - p0, 0);
        shift_bits(32'h0F, 8);
        waitn(4);
        frame_sel_n = 1'b1;
        waitn(12);
        check("R9 frame end loads", out_word, 16'h0F0F);
    endtask

    task automatic t_reset_keeps_shift;
        send_frame(32'h0000_5AA5, 16, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        waitn(6);
        check("R1 reset clears output", out_word, 16'h0);
        rst = 1'b0;
        waitn(6);
        load_strobe_n = 1'b0;
        waitn(10);
        check("R10 shift survives reset", out_word, 16'h5AA5);
    endtask

    initial begin
        waitn(6);
        t_reset();
        t_auto_load(16'hA55A);
        t_auto_load(16'h0001);
        t_auto_load(16'hFFFF);
        t_overlong();
        t_short();
        t_idle_noise();
        t_strobe();
        t_strobe_midframe();
        t_reset_keeps_shift();
        waitn(4);
        check("R3 pulse width one cycle", wide, 0);
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule